// File: doc/BRIEF.md
# NAND Cache-Sequential Page Read Sequencer

This block reads a run of consecutive NAND pages over an asynchronous 8-bit command/address/data bus and streams the bytes to a downstream consumer. A host pulses a start with a starting page, a byte column inside that page and a byte count. The sequencer then picks one of two read styles. In the plain style every page gets its own address and full array load. In the cached style the chip loads page N+1 from the array while page N is being clocked out, so later pages only pay the short cache-busy time.

The cached run opens with a normal addressed read. Each later page is then fetched with a single cache command, and the final page of the run uses the cache-end command. Short requests, and the partial first page of a request with a nonzero column, use plain reads. Every busy wait holds off for a set number of cycles before it samples the synchronized ready/busy line. The wait ends with an error if busy lasts longer than a limit set at the ports.

Top module: `nand_seq_rd`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, m_valid_o and all bus strobes (nand_we_o, nand_re_o, nand_cle_o, nand_ale_o) are low.
- R2: Cached mode is selected when the column is zero and the length is at least two pages, or when the column is nonzero and column plus length is at least three pages. Otherwise no 0x31 or 0x3F command is issued.
- R3: The first page of a cached run is read as: command 0x00, address cycles, command 0x30, ready wait, command 0x31, ready wait plus the tRR delay, data. The run starts at the start page when the column is zero and at the next page otherwise.
- R4: A page inside a cached run other than its first is fetched with exactly one command and no address cycles.
- R5: The last page of the run is the start page plus length/page_size for a nonzero column, or plus (length-1)/page_size for a zero column. That page is fetched with 0x3F, every other continuation page with 0x31, and exactly one 0x3F is issued per cached run.
- R6: The address phase sends column bits [7:0], column bits [15:8], page bits [7:0], page bits [15:8], and page bits [23:16] only when row3_i is high. The column is the request column for the request's first page and zero for every later page.
- R7: Every page outside the cached run is read as 0x00, the address cycles, 0x30, a ready wait plus tRR, and then data.
- R8: A zero-length request reads the start page with command, address and ready-wait phases, issues no read strobe and delivers no stream bytes.
- R9: After each 0x30, 0x31 or 0x3F the block waits twb_i+1 cycles before it samples ready/busy. It issues no read strobe while the chip is busy.
- R10: If ready/busy stays busy for more than busy_max_i cycles, err_o rises together with done_o and the request ends with no further bus activity. A later request clears err_o.
- R11: The number of bytes read from each page is the smaller of the bytes remaining and page_size minus that page's column.
- R12: Stream bytes follow request order. m_last_o marks the final byte of each page. While m_valid_o is high and m_ready_i is low, the byte and flag hold steady and no read strobe is issued.
- R13: nand_we_o and nand_re_o never assert together. nand_cle_o and nand_ale_o are never both high, and neither is high without nand_we_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request pulse, taken when idle |
| page_i | input | ROW_W | First page of the request |
| col_i | input | log2(PAGE_BYTES) | Byte column within the first page |
| len_i | input | LEN_W | Number of bytes to read |
| row3_i | input | 1 | Send a third row address byte |
| twb_i | input | TW | Cycles to wait after a command before sampling ready/busy |
| trr_i | input | TW | Cycles between ready and the first read strobe |
| busy_max_i | input | TW | Busy timeout limit in cycles |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse at the end of a request |
| err_o | output | 1 | Busy timeout seen on the last request |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_o | output | 1 | Write strobe; the chip latches nand_dq_o at the clock edge |
| nand_re_o | output | 1 | Read strobe; nand_dq_i is taken at the clock edge |
| nand_dq_o | output | 8 | Command or address byte |
| nand_dq_i | input | 8 | Data byte from the chip |
| nand_rb_i | input | 1 | Ready/busy line, high when ready (asynchronous) |
| m_data_o | output | 8 | Stream byte |
| m_valid_o | output | 1 | Stream byte valid |
| m_last_o | output | 1 | Final byte of a page |
| m_ready_i | input | 1 | Downstream ready |

## Verification
The bench sweeps every column of a small page against lengths from zero to past three pages, with and without the third row byte and under several backpressure patterns. A chip model tracks which page sits in its cache, so a wrong choice between 0x31 and 0x3F, or a missing cached start, shows up as wrong page data as well as a wrong command trace. The mode threshold is tested exactly at two and three pages: an off-by-one there would issue cache commands for a short read, or skip them for a long one. The model drops ready/busy only a few cycles after each command. A design that sampled the line before tWB expired would strobe data while the chip is busy. A separate stuck-busy request must end with an error and no data.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam logic [7:0] CMD_READ      = 8'h00;
  localparam logic [7:0] CMD_CONFIRM   = 8'h30;
  localparam logic [7:0] CMD_CACHE_SEQ = 8'h31;
  localparam logic [7:0] CMD_CACHE_END = 8'h3F;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PAGE, ST_CRD, ST_ADDR, ST_CCONF, ST_CCACHE,
    ST_WB, ST_RB, ST_RR, ST_DATA, ST_FIN
  } state_e;
endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rb_i,
  output logic rb_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], rb_i};
  end

  assign rb_o = sync_q[STAGES-1];
endmodule

// File: rtl/nand_seq_plan.sv
// Decides read style and page bounds of one request.
module nand_seq_plan #(
  parameter int PAGE_BYTES = 2048,
  parameter int ROW_W      = 24,
  parameter int LEN_W      = 24,
  localparam int PW        = $clog2(PAGE_BYTES)
) (
  input  logic [ROW_W-1:0] page_i,
  input  logic [PW-1:0]    col_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             seq_o,
  output logic [ROW_W-1:0] first_o,
  output logic [ROW_W-1:0] last_o,
  output logic [ROW_W-1:0] end_o
);
  logic [LEN_W:0]   span;
  logic [LEN_W-1:0] len_m1;
  logic             col_nz;

  always_comb begin
    col_nz  = |col_i;
    span    = {1'b0, len_i} + (LEN_W+1)'(col_i);
    len_m1  = len_i - 1'b1;
    seq_o   = col_nz ? (span >= (LEN_W+1)'(3 * PAGE_BYTES))
                     : ({1'b0, len_i} >= (LEN_W+1)'(2 * PAGE_BYTES));
    first_o = page_i + ROW_W'(col_nz);
    last_o  = page_i + (col_nz ? ROW_W'(len_i >> PW) : ROW_W'(len_m1 >> PW));
    end_o   = (len_i == '0) ? page_i : page_i + ROW_W'((span - 1'b1) >> PW);
  end
endmodule

// File: rtl/nand_rd_out.sv
// Single-entry stream register; room_o allows back-to-back bytes.
module nand_rd_out #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          last_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          last_o,
  output logic          room_o
);
  assign room_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      last_o  <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      last_o  <= last_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/nand_seq_rd.sv
module nand_seq_rd
  import nand_seq_pkg::*;
#(
  parameter int PAGE_BYTES  = 2048,
  parameter int ROW_W       = 24,
  parameter int LEN_W       = 24,
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2,
  localparam int PW         = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ROW_W-1:0] page_i,
  input  logic [PW-1:0]    col_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             row3_i,
  input  logic [TW-1:0]    twb_i,
  input  logic [TW-1:0]    trr_i,
  input  logic [TW-1:0]    busy_max_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_o,
  output logic             nand_re_o,
  output logic [7:0]       nand_dq_o,
  input  logic [7:0]       nand_dq_i,
  input  logic             nand_rb_i,
  output logic [7:0]       m_data_o,
  output logic             m_valid_o,
  output logic             m_last_o,
  input  logic             m_ready_i
);
  state_e           st_q;
  logic [ROW_W-1:0] pg_q, first_q, last_q, end_q;
  logic [ROW_W-1:0] pl_first, pl_last, pl_end;
  logic             pl_seq, seq_q, row3_q, inrun_q, rr_q, err_q;
  logic [PW-1:0]    col_q;
  logic [LEN_W-1:0] rem_q;
  logic [PW:0]      pb_q, room, nb;
  logic [7:0]       cmd_q;
  logic [2:0]       ai_q;
  logic [TW-1:0]    tmr_q;
  logic             rb_s, inrun_c, out_room, rd_stb;
  logic [39:0]      addr_vec;

  nand_seq_plan #(.PAGE_BYTES(PAGE_BYTES), .ROW_W(ROW_W), .LEN_W(LEN_W)) u_plan (
    .page_i(page_i), .col_i(col_i), .len_i(len_i),
    .seq_o(pl_seq), .first_o(pl_first), .last_o(pl_last), .end_o(pl_end)
  );

  nand_rb_sync #(.STAGES(SYNC_STAGES)) u_rb (
    .clk_i(clk_i), .rst_ni(rst_ni), .rb_i(nand_rb_i), .rb_o(rb_s)
  );

  nand_rd_out #(.DW(8)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(rd_stb), .data_i(nand_dq_i),
    .last_i(pb_q == (PW+1)'(1)), .ready_i(m_ready_i),
    .valid_o(m_valid_o), .data_o(m_data_o), .last_o(m_last_o), .room_o(out_room)
  );

  always_comb begin
    room     = (PW+1)'(PAGE_BYTES) - {1'b0, col_q};
    nb       = (rem_q < LEN_W'(room)) ? rem_q[PW:0] : room;
    inrun_c  = seq_q && (pg_q >= first_q) && (pg_q <= last_q);
    rd_stb   = (st_q == ST_DATA) && (pb_q != '0) && out_room;
    addr_vec = {24'(pg_q), 16'(col_q)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  pg_q <= '0;   first_q <= '0; last_q <= '0;
      end_q <= '0;      seq_q <= 1'b0; row3_q <= 1'b0; inrun_q <= 1'b0;
      rr_q <= 1'b0;     err_q <= 1'b0; col_q <= '0;   rem_q <= '0;
      pb_q <= '0;       cmd_q <= '0;  ai_q <= '0;    tmr_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          pg_q <= page_i;  col_q <= col_i;   rem_q <= len_i;  row3_q <= row3_i;
          seq_q <= pl_seq; first_q <= pl_first; last_q <= pl_last; end_q <= pl_end;
          err_q <= 1'b0;   st_q <= ST_PAGE;
        end
        ST_PAGE: begin
          pb_q    <= nb;
          rem_q   <= rem_q - LEN_W'(nb);
          inrun_q <= inrun_c;
          cmd_q   <= (pg_q == last_q) ? CMD_CACHE_END : CMD_CACHE_SEQ;
          st_q    <= (inrun_c && pg_q != first_q) ? ST_CCACHE : ST_CRD;
        end
        ST_CRD: begin ai_q <= '0; st_q <= ST_ADDR; end
        ST_ADDR: begin
          ai_q <= ai_q + 1'b1;
          if (ai_q == (row3_q ? 3'd4 : 3'd3)) st_q <= ST_CCONF;
        end
        // cached-run start skips tRR here and chains straight into 0x31
        ST_CCONF:  begin rr_q <= !inrun_q; tmr_q <= '0; st_q <= ST_WB; end
        ST_CCACHE: begin rr_q <= 1'b1;     tmr_q <= '0; st_q <= ST_WB; end
        ST_WB: if (tmr_q >= twb_i) begin tmr_q <= '0; st_q <= ST_RB; end
               else tmr_q <= tmr_q + 1'b1;
        ST_RB: if (rb_s) begin
          tmr_q <= '0;
          st_q  <= rr_q ? ST_RR : ST_CCACHE;
        end else if (tmr_q >= busy_max_i) begin
          err_q <= 1'b1;
          st_q  <= ST_FIN;
        end else tmr_q <= tmr_q + 1'b1;
        ST_RR: if (tmr_q >= trr_i) st_q <= ST_DATA;
               else tmr_q <= tmr_q + 1'b1;
        ST_DATA: if (pb_q == '0 || (rd_stb && pb_q == (PW+1)'(1))) begin
          if (pg_q == end_q) st_q <= ST_FIN;
          else begin pg_q <= pg_q + 1'b1; col_q <= '0; st_q <= ST_PAGE; end
        end else if (rd_stb) pb_q <= pb_q - 1'b1;
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    nand_we_o  = 1'b0;
    nand_cle_o = 1'b0;
    nand_ale_o = 1'b0;
    nand_dq_o  = 8'h00;
    unique case (st_q)
      ST_CRD:    begin nand_we_o = 1'b1; nand_cle_o = 1'b1; nand_dq_o = CMD_READ; end
      ST_CCONF:  begin nand_we_o = 1'b1; nand_cle_o = 1'b1; nand_dq_o = CMD_CONFIRM; end
      ST_CCACHE: begin nand_we_o = 1'b1; nand_cle_o = 1'b1; nand_dq_o = cmd_q; end
      ST_ADDR:   begin nand_we_o = 1'b1; nand_ale_o = 1'b1;
                       nand_dq_o = addr_vec[{ai_q, 3'b000} +: 8]; end
      default: ;
    endcase
  end

  assign nand_re_o = rd_stb;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = (st_q == ST_FIN);
  assign err_o     = err_q;
endmodule

// File: rtl/nand_seq_rd_chk.sv
module nand_seq_rd_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       nand_cle_o,
  input logic       nand_ale_o,
  input logic       nand_we_o,
  input logic       nand_re_o,
  input logic [7:0] m_data_o,
  input logic       m_valid_o,
  input logic       m_last_o,
  input logic       m_ready_i
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !nand_we_o && !nand_re_o && !nand_cle_o && !nand_ale_o);

  a_r13_we_re_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_we_o && nand_re_o));

  a_r13_latch_needs_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nand_cle_o || nand_ale_o) |-> nand_we_o && !(nand_cle_o && nand_ale_o));

  a_r12_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_data_o) && $stable(m_last_o));

  a_r12_no_read_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_re_o |-> !m_valid_o || m_ready_i);

  a_r10_err_ends_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> done_o);
endmodule

bind nand_seq_rd nand_seq_rd_chk u_chk (.*);

// File: tb/tb_nand_seq_rd.sv
module tb_nand_seq_rd;
  localparam int PG = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, row3 = 1'b0, m_ready = 1'b1;
  logic [23:0] page = '0;
  logic [2:0]  col = '0;
  logic [11:0] len = '0;
  logic busy_o, done_o, err_o, cle, ale, we, re, m_valid, m_last;
  logic [7:0] dq_o, dq_i, m_data;
  logic rb_m;

  int tests = 0, fails = 0, cyc = 0, cyc_n = 0, rmode = 0;
  bit stuck = 0;

  int act_ev [64]; int n_act = 0;
  int exp_ev [64]; int n_exp = 0;
  int act_d  [64]; int act_l [64]; int n_d = 0;
  int recnt = 0, viol_busy = 0, viol_strobe = 0;

  always #5 clk = ~clk;

  nand_seq_rd #(.PAGE_BYTES(PG), .ROW_W(24), .LEN_W(12), .TW(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .page_i(page), .col_i(col),
    .len_i(len), .row3_i(row3), .twb_i(8'd6), .trr_i(8'd2), .busy_max_i(8'd40),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_o(we), .nand_re_o(re),
    .nand_dq_o(dq_o), .nand_dq_i(dq_i), .nand_rb_i(rb_m),
    .m_data_o(m_data), .m_valid_o(m_valid), .m_last_o(m_last), .m_ready_i(m_ready)
  );

  // chip model: cache page tracking and ready/busy
  logic [7:0]  abuf [5];
  logic [2:0]  acnt;
  logic [23:0] out_page, loaded;
  logic [7:0]  out_col;
  int dly, bt;
  assign dq_i = out_page[7:0] * 8'd7 + out_col;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_m <= 1'b1; dly <= 0; bt <= 0; acnt <= '0;
      out_page <= '0; loaded <= '0; out_col <= '0;
      for (int i = 0; i < 5; i++) abuf[i] <= '0;
    end else begin
      if (we && ale) begin abuf[acnt] <= dq_o; acnt <= acnt + 1'b1; end
      if (re) out_col <= out_col + 1'b1;
      if (we && cle && (dq_o == 8'h30 || dq_o == 8'h31 || dq_o == 8'h3F)) begin
        dly <= 3;
        bt  <= (dq_o == 8'h30) ? 8 : 4;
        if (dq_o == 8'h30) begin
          out_page <= {row3 ? abuf[4] : 8'h00, abuf[3], abuf[2]};
          loaded   <= {row3 ? abuf[4] : 8'h00, abuf[3], abuf[2]};
          out_col  <= abuf[0];
        end else begin
          out_page <= loaded;
          out_col  <= '0;
          if (dq_o == 8'h31) loaded <= loaded + 1'b1;
        end
      end else if (we && cle) begin
        acnt <= '0;
      end else if (dly != 0) begin
        dly <= dly - 1;
        if (dly == 1) rb_m <= 1'b0;
      end else if (!rb_m && !stuck) begin
        if (bt == 0) rb_m <= 1'b1; else bt <= bt - 1;
      end
    end
  end

  task automatic push_act(int ev);
    if (n_act < 64) act_ev[n_act] = ev;
    n_act++;
  endtask

  // drive ready, then sample away from the edge
  always @(negedge clk) begin
    cyc_n++;
    case (rmode)
      0:       m_ready = 1'b1;
      1:       m_ready = (cyc_n % 2) == 0;
      default: m_ready = (cyc_n % 3) != 0;
    endcase
    #1;
    if (rst_n) begin
      if (m_valid && m_ready) begin
        if (n_d < 64) begin act_d[n_d] = m_data; act_l[n_d] = m_last; end
        n_d++;
      end
      if (we) begin
        if (recnt > 0) begin push_act(3*256 + recnt); recnt = 0; end
        push_act((cle ? 1 : 2)*256 + dq_o);
      end
      if (re) begin recnt++; if (!rb_m) viol_busy++; end
      if ((we && re) || (cle && ale) || ((cle || ale) && !we)) viol_strobe++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL R9 watchdog: actual %0d cycles, expected below %0d", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, string what, int a, int e);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, a, e);
    end
  endtask

  task automatic push_exp(int ev);
    if (n_exp < 64) exp_ev[n_exp] = ev;
    n_exp++;
  endtask

  function automatic bit is_seq(int c, int l);
    return (c == 0 && l >= 2*PG) || (c != 0 && c + l >= 3*PG);
  endfunction

  task automatic build_exp(int p, int c, int l, bit r3);
    bit s = is_seq(c, l);
    int np = (l == 0) ? 1 : (c + l - 1) / PG + 1;
    int first = p + ((c != 0) ? 1 : 0);
    int last = (c == 0) ? p + (l - 1) / PG : p + l / PG;
    int rem = l, cl = c;
    n_exp = 0;
    for (int i = 0; i < np; i++) begin
      int pg = p + i;
      int nbt = (rem < PG - cl) ? rem : PG - cl;
      bit inrun = s && pg >= first && pg <= last;
      if (inrun && pg != first) push_exp(256 + ((pg == last) ? 8'h3F : 8'h31));
      else begin
        push_exp(256 + 8'h00);
        push_exp(512 + cl); push_exp(512 + 0);
        push_exp(512 + (pg & 255)); push_exp(512 + ((pg >> 8) & 255));
        if (r3) push_exp(512 + ((pg >> 16) & 255));
        push_exp(256 + 8'h30);
        if (inrun) push_exp(256 + 8'h31);
      end
      if (nbt > 0) push_exp(3*256 + nbt);
      rem -= nbt; cl = 0;
    end
  endtask

  function automatic int cnt_ev(bit use_act, int val);
    int n = 0;
    int lim = use_act ? n_act : n_exp;
    for (int k = 0; k < lim && k < 64; k++)
      if ((use_act ? act_ev[k] : exp_ev[k]) == val) n++;
    return n;
  endfunction

  function automatic int type_mis(int t);
    int a [64]; int b [64];
    int na = 0, nb2 = 0, m = 0;
    for (int k = 0; k < n_act && k < 64; k++) if (act_ev[k] / 256 == t) begin a[na] = act_ev[k]; na++; end
    for (int k = 0; k < n_exp && k < 64; k++) if (exp_ev[k] / 256 == t) begin b[nb2] = exp_ev[k]; nb2++; end
    if (na != nb2) m++;
    for (int k = 0; k < na && k < nb2; k++) if (a[k] != b[k]) m++;
    return m;
  endfunction

  task automatic run_one(int p, int c, int l, bit r3, int mode, bit want_err);
    int w = 0;
    bit got_done = 0, got_err = 0;
    n_act = 0; n_d = 0; recnt = 0; viol_busy = 0; viol_strobe = 0;
    build_exp(p, c, l, r3);
    @(negedge clk);
    rmode = mode; row3 = r3; page = 24'(p); col = 3'(c); len = 12'(l); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!got_done && w < 3000) begin
      @(negedge clk); #2; w++;
      if (done_o) begin got_done = 1; got_err = err_o; end
    end
    while (m_valid && w < 3000) begin @(negedge clk); #2; w++; end
    if (recnt > 0) begin push_act(3*256 + recnt); recnt = 0; end
    chk(got_done, "R9", "request completion", got_done, 1);
    if (want_err) begin
      chk(got_err, "R10", "timeout flag", got_err, 1);
      chk(n_d == 0, "R10", "bytes after timeout", n_d, 0);
      return;
    end
    chk(!got_err, "R10", "no timeout", got_err, 0);
    begin
      int nc = cnt_ev(1, 256 + 8'h31) + cnt_ev(1, 256 + 8'h3F);
      int tmis = 0, dmis = 0, lmis = 0;
      chk((nc > 0) == is_seq(c, l), "R2", "cached mode used", nc > 0, is_seq(c, l));
      chk(cnt_ev(1, 256 + 8'h3F) == cnt_ev(0, 256 + 8'h3F), "R5", "cache-end count",
          cnt_ev(1, 256 + 8'h3F), cnt_ev(0, 256 + 8'h3F));
      chk(cnt_ev(1, 256 + 8'h31) == cnt_ev(0, 256 + 8'h31), "R4", "cache-seq count",
          cnt_ev(1, 256 + 8'h31), cnt_ev(0, 256 + 8'h31));
      chk(type_mis(2) == 0, "R6", "address bytes mismatches", type_mis(2), 0);
      chk(type_mis(3) == 0, "R11", "page byte count mismatches", type_mis(3), 0);
      for (int k = 0; k < n_exp && k < 64; k++) if (k >= n_act || act_ev[k] != exp_ev[k]) tmis++;
      chk(n_act == n_exp && tmis == 0, is_seq(c, l) ? "R3" : "R7", "bus trace", n_act, n_exp);
      if (l == 0) chk(n_d == 0 && cnt_ev(1, 0) == 0 && type_mis(3) == 0, "R8", "zero-length bytes", n_d, 0);
      for (int k = 0; k < l && k < n_d && k < 64; k++) begin
        int o = c + k;
        int pg = p + o / PG;
        int e = (pg * 7 + o % PG) & 255;
        int el = ((o % PG) == PG - 1 || k == l - 1) ? 1 : 0;
        if (act_d[k] != e) dmis++;
        if (act_l[k] != el) lmis++;
      end
      chk(n_d == l && dmis == 0, "R12", "stream bytes", n_d, l);
      chk(lmis == 0, "R12", "last flag mismatches", lmis, 0);
      chk(viol_busy == 0, "R9", "reads while busy", viol_busy, 0);
      chk(viol_strobe == 0, "R13", "strobe overlaps", viol_strobe, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(!busy_o && !done_o && !m_valid && !we && !re && !cle && !ale, "R1",
        "reset outputs", busy_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int c = 0; c < PG; c++)
      for (int l = 0; l < 28; l++)
        run_one(24'h12FFFA + (c + l) % 8, c, l, bit'((c + l) % 2), (c + 2*l) % 3, 1'b0);
    stuck = 1;
    run_one(24'h000040, 0, 5, 1'b0, 0, 1'b1);
    stuck = 0;
    repeat (20) @(negedge clk);
    run_one(24'h000041, 3, 7, 1'b1, 1, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule